// File: doc/BRIEF.md
# Capture compare PWM unit

This block is a single timer-driven channel that can act in one of three ways, picked by a 4-bit mode input. As a capture channel it watches an input pin and, on a chosen kind of pin event, stores the value of a wide free-running timer in its 16-bit data register. As a compare channel it watches the same wide timer and reacts when it reaches the register value: it can drive the output pin, ask for the timer to be cleared, or ask for the timer to be cleared and also start an A/D conversion. As a PWM channel it produces a pulse train whose period is set by an 8-bit period input and whose high time is a 10-bit duty value held in the data register.

The timers are not part of the block. The wide timer arrives as one input. The PWM time base arrives as an 8-bit count plus a 2-bit low extension, which together form a 10-bit count. Software reaches the data register through a plain write strobe and a read-back bus. The block reports events on a one-cycle interrupt pulse.

Top module: `ccp_channel`

## Requirements
- R1: After reset the data register reads 0, and the output pin, the interrupt, the timer-reset request and the A/D trigger are all low. Modes 0000 to 0011 are off: the pin stays low and no interrupt is raised. In the capture modes (01xx) the pin stays low.
- R2: A write strobe loads the whole data register and the read bus shows it from the next cycle. In capture mode, on the chosen pin event, the wide timer value is stored in the register and one interrupt pulse follows. A write in the same cycle takes priority over a capture.
- R3: Mode 0100 captures on every falling edge of the pin and ignores rising edges. Mode 0101 captures on every rising edge. The pin passes through a two-stage synchronizer first.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The edges in between change neither the register nor the interrupt.
- R5: Any change of the mode input clears the count of rising edges, so after a change the next capture in mode 0110 needs four new rising edges.
- R6: In compare mode (10xx), one interrupt pulse is raised in the cycle after the wide timer first equals the register. It is not raised again while the two stay equal. On entering mode 1001 the pin goes high; on entering any other compare mode it goes low.
- R7: On a compare match, mode 1000 drives the pin high and mode 1001 drives it low. The pin then holds that level.
- R8: On a compare match, mode 1010 gives a one-cycle timer-reset request. Mode 1011 gives the timer-reset request and an A/D-start pulse in the same cycle. The pin is not changed in either mode.
- R9: In PWM mode (11xx) the duty value is the register's upper 8 bits joined above its lowest 2 bits. The PWM count is the 8-bit count joined above the 2-bit extension. Each period the pin is high for exactly duty counts.
- R10: A period ends when the PWM count equals the period input joined above binary 11. On that count the next cycle has the pin high (unless duty is 0), one interrupt pulse and a timer-reset request.
- R11: The duty value is taken into use only at a period end. A write made during a period has no effect until the following period.
- R12: A duty of 0 keeps the pin low for the whole period. A duty of at least the period length keeps it high for the whole period.
- R13: The interrupt is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Mode select |
| reg_we_i | input | 1 | Data register write strobe |
| reg_wdata_i | input | TW | Data register write value |
| reg_rdata_o | output | TW | Data register read value |
| tmr_wide_i | input | TW | Free-running timer value for capture and compare |
| tmr_per_i | input | PW | PWM time base, upper part |
| tmr_ext_i | input | XW | PWM time base, 2-bit low extension |
| period_i | input | PW | PWM period value |
| pin_i | input | 1 | Capture input pin |
| pin_o | output | 1 | Channel output pin |
| irq_o | output | 1 | Interrupt pulse |
| tmr_rst_o | output | 1 | Request to clear the time base |
| adc_start_o | output | 1 | A/D conversion start pulse |

## Verification
The bench builds the block with its default sizes: a 16-bit wide timer, an 8-bit period timer and a 2-bit extension, so all 10 duty bits and all 16 capture bits are exercised. It drives the PWM count from its own model with a period input of 3, which gives 16-count periods. That keeps many full periods, duty changes and the zero and oversized duty cases within a few hundred cycles. Capture prescaling up to sixteen edges is covered in full at this size.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [1:0] {
    GRP_OFF = 2'b00,
    GRP_CAP = 2'b01,
    GRP_CMP = 2'b10,
    GRP_PWM = 2'b11
  } grp_e;

  localparam logic [1:0] CMP_SET = 2'd0;
  localparam logic [1:0] CMP_CLR = 2'd1;
  localparam logic [1:0] CMP_RST = 2'd2;
  localparam logic [1:0] CMP_ADC = 2'd3;

  function automatic grp_e grp_of(input logic [3:0] m);
    return grp_e'(m[3:2]);
  endfunction

endpackage

// File: rtl/ccp_capture_unit.sv
module ccp_capture_unit #(
  parameter int DIV_MID = 4,
  parameter int DIV_HI  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] sel,
  input  logic       pin_i,
  output logic       fire
);
  localparam int CNT_W = $clog2(DIV_HI);

  logic             sync1, sync2, prev;
  logic             rise, fall, last;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise    = sync2 & ~prev;
  assign fall    = ~sync2 & prev;
  assign cnt_top = sel[0] ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_MID - 1);
  assign last    = (cnt == cnt_top);

  always_comb begin
    case (sel)
      2'd0:    fire = en & fall;
      2'd1:    fire = en & rise;
      default: fire = en & rise & last;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      cnt <= '0;
    end else if (rise && sel[1]) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ccp_compare_unit.sv
module ccp_compare_unit #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] timer,
  input  logic [TW-1:0] target,
  output logic          hit
);
  logic eq, eq_q;

  assign eq  = (timer == target);
  assign hit = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

endmodule

// File: rtl/ccp_pwm_unit.sv
module ccp_pwm_unit #(
  parameter int PW = 8,
  parameter int XW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PW+XW-1:0] count,
  input  logic [PW-1:0]    period,
  input  logic [PW+XW-1:0] duty_buf,
  output logic             pin,
  output logic             wrap
);
  localparam int DW = PW + XW;

  logic [DW-1:0] duty_act;
  logic          drop;

  assign wrap = en & (count == {period, {XW{1'b1}}});
  assign drop = en & (duty_act != '0) & (count == duty_act - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pin      <= 1'b0;
      duty_act <= '0;
    end else if (wrap) begin
      pin      <= (duty_buf != '0);
      duty_act <= duty_buf;
    end else if (drop) begin
      pin      <= 1'b0;
    end
  end

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int TW = 16,
  parameter int PW = 8,
  parameter int XW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode_i,
  input  logic          reg_we_i,
  input  logic [TW-1:0] reg_wdata_i,
  output logic [TW-1:0] reg_rdata_o,
  input  logic [TW-1:0] tmr_wide_i,
  input  logic [PW-1:0] tmr_per_i,
  input  logic [XW-1:0] tmr_ext_i,
  input  logic [PW-1:0] period_i,
  input  logic          pin_i,
  output logic          pin_o,
  output logic          irq_o,
  output logic          tmr_rst_o,
  output logic          adc_start_o
);
  localparam int DW = PW + XW;

  logic [TW-1:0] pair_q;
  logic [3:0]    mode_q;
  grp_e          grp_i, grp_q;
  logic          mode_chg;
  logic          cap_fire, cmp_hit, cmp_act;
  logic          pwm_wrap, pwm_pin, cmp_pin;
  logic [DW-1:0] duty_buf;

  assign grp_i    = grp_of(mode_i);
  assign grp_q    = grp_of(mode_q);
  assign mode_chg = (mode_i != mode_q);
  assign duty_buf = {pair_q[TW-1 -: PW], pair_q[XW-1:0]};
  assign cmp_act  = cmp_hit & (grp_i == GRP_CMP);

  ccp_capture_unit u_cap (
    .clk     (clk),
    .rst     (rst),
    .en      (grp_i == GRP_CAP),
    .restart (mode_chg),
    .sel     (mode_i[1:0]),
    .pin_i   (pin_i),
    .fire    (cap_fire)
  );

  ccp_compare_unit #(.TW(TW)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .timer  (tmr_wide_i),
    .target (pair_q),
    .hit    (cmp_hit)
  );

  ccp_pwm_unit #(.PW(PW), .XW(XW)) u_pwm (
    .clk      (clk),
    .rst      (rst),
    .en       (grp_i == GRP_PWM),
    .count    ({tmr_per_i, tmr_ext_i}),
    .period   (period_i),
    .duty_buf (duty_buf),
    .pin      (pwm_pin),
    .wrap     (pwm_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q      <= '0;
      mode_q      <= '0;
      cmp_pin     <= 1'b0;
      irq_o       <= 1'b0;
      tmr_rst_o   <= 1'b0;
      adc_start_o <= 1'b0;
    end else begin
      mode_q <= mode_i;

      if (reg_we_i)
        pair_q <= reg_wdata_i;
      else if (cap_fire)
        pair_q <= tmr_wide_i;

      if (mode_chg && grp_i == GRP_CMP)
        cmp_pin <= (mode_i[1:0] == CMP_CLR);
      else if (cmp_act && !mode_i[1])
        cmp_pin <= (mode_i[1:0] == CMP_SET);

      irq_o       <= cap_fire | cmp_act | pwm_wrap;
      tmr_rst_o   <= (cmp_act & mode_i[1]) | pwm_wrap;
      adc_start_o <= cmp_act & (mode_i[1:0] == CMP_ADC);
    end
  end

  always_comb begin
    case (grp_q)
      GRP_PWM: pin_o = pwm_pin;
      GRP_CMP: pin_o = cmp_pin;
      default: pin_o = 1'b0;
    endcase
  end

  assign reg_rdata_o = pair_q;

endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    mode_i,
  input logic          reg_we_i,
  input logic [TW-1:0] reg_rdata_o,
  input logic          pin_o,
  input logic          irq_o,
  input logic          tmr_rst_o,
  input logic          adc_start_o
);

  assert_irq_single_R13: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R8: an A/D start only comes with a timer-reset request and an interrupt
  assert_adc_with_reset_R8: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> (tmr_rst_o && irq_o));

  // R10: every timer-reset request is paired with an interrupt
  assert_reset_with_irq_R10: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_o |-> irq_o);

  // R2: the data register moves only through a write or a capture event
  assert_pair_change_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(reg_rdata_o) && !$past(reg_we_i)) |-> irq_o);

  // R1: off and capture modes keep the pin low
  assert_pin_low_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i[3]) == 1'b0) |-> !pin_o);

  // R10: in steady PWM mode the pin only rises at a period end
  assert_pwm_rise_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(pin_o) && $past(mode_i[3:2]) == 2'b11 && $past(mode_i[3:2], 2) == 2'b11)
      |-> irq_o);

endmodule

bind ccp_channel ccp_channel_chk #(.TW(TW)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .pin_o       (pin_o),
  .irq_o       (irq_o),
  .tmr_rst_o   (tmr_rst_o),
  .adc_start_o (adc_start_o)
);

// File: tb/test_ccp_channel.sv
module test_ccp_channel;
  localparam int CLK_PER = 10;
  localparam int TW = 16;
  localparam int PW = 8;
  localparam int XW = 2;
  localparam int WD_CYCLES = 50000;
  localparam logic [PW-1:0] PER = 8'd3;
  localparam int PLEN = (PER + 1) * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    mode_i = 4'b0000;
  logic          reg_we_i = 1'b0;
  logic [TW-1:0] reg_wdata_i = '0;
  logic [TW-1:0] reg_rdata_o;
  logic [TW-1:0] tmr_wide_i = '0;
  logic [PW-1:0] tmr_per_i;
  logic [XW-1:0] tmr_ext_i;
  logic [PW-1:0] period_i = PER;
  logic          pin_i = 1'b0;
  logic          pin_o, irq_o, tmr_rst_o, adc_start_o;

  logic [PW+XW-1:0] tb_cnt;
  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;
  int rst_seen = 0;
  int adc_seen = 0;

  always #(CLK_PER/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst || tb_cnt == {period_i, 2'b11}) tb_cnt <= '0;
    else tb_cnt <= tb_cnt + 1'b1;
  end
  assign tmr_per_i = tb_cnt[PW+XW-1:XW];
  assign tmr_ext_i = tb_cnt[XW-1:0];

  always @(negedge clk) begin
    if (irq_o) irq_seen++;
    if (tmr_rst_o) rst_seen++;
    if (adc_start_o) adc_seen++;
  end

  ccp_channel #(.TW(TW), .PW(PW), .XW(XW)) i_ccp_channel (
    .clk(clk), .rst(rst), .mode_i(mode_i), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .tmr_wide_i(tmr_wide_i), .tmr_per_i(tmr_per_i), .tmr_ext_i(tmr_ext_i),
    .period_i(period_i), .pin_i(pin_i), .pin_o(pin_o), .irq_o(irq_o),
    .tmr_rst_o(tmr_rst_o), .adc_start_o(adc_start_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pair(input logic [TW-1:0] v);
    @(negedge clk);
    reg_we_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode_i = m;
    wait_n(2);
  endtask

  task automatic pulse_pin();
    pin_i = 1'b1;
    wait_n(4);
    pin_i = 1'b0;
    wait_n(4);
  endtask

  task automatic t_reset();
    chk("R1", "reset pair", reg_rdata_o, 0);
    chk("R1", "reset pin", pin_o, 0);
    chk("R1", "reset irq", irq_o, 0);
    chk("R1", "reset tmr_rst", tmr_rst_o, 0);
    chk("R1", "reset adc", adc_start_o, 0);
  endtask

  task automatic t_off();
    int r0;
    set_mode(4'b0010);
    r0 = irq_seen;
    tmr_wide_i = 16'h0000;
    pulse_pin();
    pulse_pin();
    chk("R1", "off irq count", irq_seen - r0, 0);
    chk("R1", "off pin", pin_o, 0);
    chk("R1", "off pair", reg_rdata_o, 0);
  endtask

  task automatic t_capture_edges();
    int r0;
    wr_pair(16'hAAAA);
    wait_n(1);
    chk("R2", "write readback", reg_rdata_o, 16'hAAAA);
    set_mode(4'b0101);
    tmr_wide_i = 16'h1234;
    r0 = irq_seen;
    pulse_pin();
    chk("R2", "rise capture value", reg_rdata_o, 16'h1234);
    chk("R3", "rise capture irq", irq_seen - r0, 1);
    chk("R1", "capture pin low", pin_o, 0);
    set_mode(4'b0100);
    tmr_wide_i = 16'h2222;
    r0 = irq_seen;
    pin_i = 1'b1;
    wait_n(4);
    chk("R3", "falling mode ignores rise", reg_rdata_o, 16'h1234);
    pin_i = 1'b0;
    wait_n(4);
    chk("R3", "falling capture value", reg_rdata_o, 16'h2222);
    chk("R3", "falling capture irq", irq_seen - r0, 1);
  endtask

  task automatic t_prescale();
    int r0;
    set_mode(4'b0110);
    r0 = irq_seen;
    for (int i = 0; i < 3; i++) begin
      tmr_wide_i = 16'h0100 + 16'(i);
      pulse_pin();
    end
    chk("R4", "div4 no early capture", reg_rdata_o, 16'h2222);
    chk("R4", "div4 no early irq", irq_seen - r0, 0);
    tmr_wide_i = 16'h0103;
    pulse_pin();
    chk("R4", "div4 capture", reg_rdata_o, 16'h0103);
    chk("R4", "div4 irq", irq_seen - r0, 1);

    r0 = irq_seen;
    for (int i = 0; i < 2; i++) begin
      tmr_wide_i = 16'h0300 + 16'(i);
      pulse_pin();
    end
    set_mode(4'b0101);
    set_mode(4'b0110);
    for (int i = 0; i < 3; i++) begin
      tmr_wide_i = 16'h0400 + 16'(i);
      pulse_pin();
    end
    chk("R5", "mode change clears edge count", irq_seen - r0, 0);
    tmr_wide_i = 16'h0403;
    pulse_pin();
    chk("R5", "capture after four fresh edges", reg_rdata_o, 16'h0403);

    set_mode(4'b0111);
    r0 = irq_seen;
    for (int i = 0; i < 15; i++) begin
      tmr_wide_i = 16'h0500 + 16'(i);
      pulse_pin();
    end
    chk("R4", "div16 no early capture", reg_rdata_o, 16'h0403);
    tmr_wide_i = 16'h050F;
    pulse_pin();
    chk("R4", "div16 capture", reg_rdata_o, 16'h050F);
    chk("R4", "div16 irq", irq_seen - r0, 1);
  endtask

  task automatic cmp_hit_step(input logic [3:0] m, input string req,
                              input logic pin_before, input logic pin_after,
                              input int exp_rst, input int exp_adc);
    int r0, t0, a0;
    tmr_wide_i = 16'h04FF;
    set_mode(m);
    wait_n(1);
    chk("R6", "inactive pin on entry", pin_o, pin_before);
    r0 = irq_seen; t0 = rst_seen; a0 = adc_seen;
    tmr_wide_i = 16'h0500;
    wait_n(2);
    chk(req, "pin after match", pin_o, pin_after);
    chk("R6", "match irq", irq_seen - r0, 1);
    chk(req, "timer reset requests", rst_seen - t0, exp_rst);
    chk(req, "adc pulses", adc_seen - a0, exp_adc);
    wait_n(3);
    chk("R6", "single irq while equal", irq_seen - r0, 1);
  endtask

  task automatic t_compare();
    set_mode(4'b0000);
    wr_pair(16'h0500);
    cmp_hit_step(4'b1000, "R7", 1'b0, 1'b1, 0, 0);
    cmp_hit_step(4'b1001, "R7", 1'b1, 1'b0, 0, 0);
    cmp_hit_step(4'b1010, "R8", 1'b0, 1'b0, 1, 0);
    cmp_hit_step(4'b1011, "R8", 1'b0, 1'b0, 1, 1);
  endtask

  task automatic measure(output int hi, input logic do_wr, input logic [TW-1:0] nv);
    while (!irq_o) @(negedge clk);
    chk("R10", "period end timer reset", tmr_rst_o, 1);
    hi = 0;
    for (int i = 0; i < PLEN; i++) begin
      if (do_wr && i == 0) begin reg_we_i = 1'b1; reg_wdata_i = nv; end
      if (i == 1) reg_we_i = 1'b0;
      if (pin_o) hi++;
      @(negedge clk);
    end
  endtask

  task automatic t_pwm();
    int hi;
    set_mode(4'b0000);
    wr_pair(16'h0101);
    set_mode(4'b1100);
    measure(hi, 1'b0, '0);
    chk("R9", "duty 5 high counts", hi, 5);
    measure(hi, 1'b0, '0);
    chk("R10", "duty 5 second period", hi, 5);
    measure(hi, 1'b1, 16'h0202);
    chk("R11", "write deferred to next period", hi, 5);
    measure(hi, 1'b0, '0);
    chk("R11", "new duty 10 active", hi, 10);
    measure(hi, 1'b1, 16'h0000);
    chk("R11", "duty 10 before zero", hi, 10);
    measure(hi, 1'b0, '0);
    chk("R12", "duty 0 stays low", hi, 0);
    measure(hi, 1'b1, 16'h0500);
    chk("R12", "zero period before big duty", hi, 0);
    measure(hi, 1'b0, '0);
    chk("R12", "duty above period stays high", hi, PLEN);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_off();
    t_capture_edges();
    t_prescale();
    t_compare();
    t_pwm();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule